// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Update

This block is the purely combinational arithmetic and logic unit of a small 8-bit accumulator processor. A decoder outside the block gives it a 5-bit operation code, the accumulator, a second byte operand, a pair of 16-bit operands and the four incoming condition flags: zero (Z), subtract (N), half-carry (H) and carry (C). The block returns an 8-bit result with its write enable, a 16-bit result with its own write enable, and the four updated flags. Every output settles within the cycle in which its inputs are presented.

The byte operations are add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR, increment, decrement, accumulator complement, set carry and complement carry. There are two wide operations. The first adds one register pair to another. The second adds a signed byte offset to a 16-bit stack pointer. Each operation has its own rule for the flags: a flag is either computed, forced to 0 or 1, or passed through from the input. Half-carry comes from bit 3 on byte adds and from bit 4 on byte subtracts.

Top module: `alu8_core`

## Requirements
- R1: Code 0x00 (add) and code 0x01 (add with carry in C) write A+B(+C) to the byte result with write enable high. Z is set when the byte result is zero. N is cleared. H is set on a carry out of bit 3. C is set on a carry out of bit 7.
- R2: Code 0x02 (subtract) and code 0x03 (subtract with borrow in C) write A-B(-C) with write enable high. N is set. H is set on a borrow from bit 4. C is set when B (plus the borrow-in) exceeds A. Z is set when the result is zero.
- R3: Code 0x04 (compare) sets the flags exactly as code 0x02 does, with the byte write enable low.
- R4: Code 0x05 (AND) forces H=1 and C=0. Codes 0x06 (OR) and 0x07 (XOR) force H=0 and C=0. All three write the result, set Z from it and clear N.
- R5: Code 0x08 (increment A) and code 0x09 (decrement A) write the result, set Z from it, set N=0 or N=1 respectively, compute H as the add or subtract rule does, and pass C through unchanged.
- R6: Code 0x0A (complement) writes the bitwise inverse of A, sets N and H, and passes Z and C through.
- R7: Code 0x0B forces C=1 and code 0x0C inverts C. Both clear N and H, pass Z through and keep the byte write enable low.
- R8: Code 0x0D writes the 16-bit sum of the two pair operands to the wide result with the wide write enable high. N is cleared. H is set on a carry out of bit 11. C is set on a carry out of bit 15. Z passes through.
- R9: Code 0x0E adds the sign-extended byte operand to the first pair operand and writes the sum to the wide result with the wide write enable high. Z and N are forced to 0. H and C come from carries out of bits 3 and 7 of the low-byte addition.
- R10: Codes 0x0F to 0x1F are undefined. For these codes the byte result equals A, both write enables are low and all four flags pass through unchanged.
- R11: In every byte operation the wide write enable is low. In every wide operation the byte write enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second byte operand B, or signed offset for code 0x0E |
| pair_a_i | input | 16 | First wide operand (destination pair or stack pointer) |
| pair_b_i | input | 16 | Second wide operand for code 0x0D |
| z_i | input | 1 | Incoming zero flag |
| n_i | input | 1 | Incoming subtract flag |
| h_i | input | 1 | Incoming half-carry flag |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 8 | Byte result |
| res_we_o | output | 1 | Byte result write enable |
| wide_o | output | 16 | Wide result |
| wide_we_o | output | 1 | Wide result write enable |
| z_o | output | 1 | Updated zero flag |
| n_o | output | 1 | Updated subtract flag |
| h_o | output | 1 | Updated half-carry flag |
| c_o | output | 1 | Updated carry flag |

## Verification
The block has no registers, so every result and flag is due in the same cycle as the operands that produce it, with zero cycles of latency. The bench drives a new operation on each falling edge and pushes the expected item at the same moment. It compares the outputs 1 ns after the next rising edge, half a period after the inputs changed and well before they change again, so exactly one item is in flight in each cycle. Every code, including the undefined ones, is swept across the corner bytes 0x00, 0x0F, 0x10, 0x7F, 0x80 and 0xFF with both carry-in values. Random operands and directed wide-operand edge cases follow the sweep.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int WIDE_W = 16;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'h00,
    OP_ADC   = 5'h01,
    OP_SUB   = 5'h02,
    OP_SBC   = 5'h03,
    OP_CMP   = 5'h04,
    OP_AND   = 5'h05,
    OP_OR    = 5'h06,
    OP_XOR   = 5'h07,
    OP_INC   = 5'h08,
    OP_DEC   = 5'h09,
    OP_NOT   = 5'h0A,
    OP_SETC  = 5'h0B,
    OP_FLIPC = 5'h0C,
    OP_PADD  = 5'h0D,
    OP_SPOFS = 5'h0E
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         half_o,
  output logic         carry_o
);
  localparam int NIB = W / 2;

  // Full-width add or subtract; bit W is the carry or the borrow.
  function automatic logic [W:0] full_op(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic ci, input logic s);
    logic [W:0] cx;
    cx = {{W{1'b0}}, ci};
    if (s) return {1'b0, x} - {1'b0, y} - cx;
    else   return {1'b0, x} + {1'b0, y} + cx;
  endfunction

  // Low-nibble carry/borrow: carry out of bit NIB-1 on add, borrow from bit NIB on subtract.
  function automatic logic nib_out(input logic [NIB-1:0] x, input logic [NIB-1:0] y,
                                   input logic ci, input logic s);
    logic [NIB:0] t;
    logic [NIB:0] cx;
    cx = {{NIB{1'b0}}, ci};
    if (s) t = {1'b0, x} - {1'b0, y} - cx;
    else   t = {1'b0, x} + {1'b0, y} + cx;
    return t[NIB];
  endfunction

  assign {carry_o, res_o} = full_op(a_i, b_i, cin_i, sub_i);
  assign half_o           = nib_out(a_i[NIB-1:0], b_i[NIB-1:0], cin_i, sub_i);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,   // 0 and, 1 or, 2 xor
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu8_wide.sv
module alu8_wide #(
  parameter int W  = 8,
  parameter int NW = 16
) (
  input  logic [NW-1:0] base_i,
  input  logic [NW-1:0] pair_i,
  input  logic [W-1:0]  ofs_i,
  input  logic          ofs_mode_i,
  output logic [NW-1:0] res_o,
  output logic          half_o,
  output logic          carry_o
);
  localparam int NIB = W / 2;
  localparam int HW  = NW - NIB;   // half-carry taken out of bit HW-1 for pair adds

  function automatic logic cout_at_hw(input logic [NW-1:0] x, input logic [NW-1:0] y);
    logic [HW:0] t;
    t = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]};
    return t[HW];
  endfunction

  function automatic logic cout_at_w(input logic [NW-1:0] x, input logic [NW-1:0] y);
    logic [W:0] t;
    t = {1'b0, x[W-1:0]} + {1'b0, y[W-1:0]};
    return t[W];
  endfunction

  function automatic logic cout_at_nib(input logic [NW-1:0] x, input logic [NW-1:0] y);
    logic [NIB:0] t;
    t = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]};
    return t[NIB];
  endfunction

  logic [NW-1:0] addend;
  logic          full_cout;

  assign addend = ofs_mode_i ? {{(NW-W){ofs_i[W-1]}}, ofs_i} : pair_i;
  assign {full_cout, res_o} = {1'b0, base_i} + {1'b0, addend};

  assign half_o  = ofs_mode_i ? cout_at_nib(base_i, addend) : cout_at_hw(base_i, addend);
  assign carry_o = ofs_mode_i ? cout_at_w(base_i, addend)   : full_cout;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = alu8_pkg::DATA_W,
  parameter int WW = alu8_pkg::WIDE_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   opnd_i,
  input  logic [WW-1:0]   pair_a_i,
  input  logic [WW-1:0]   pair_b_i,
  input  logic            z_i,
  input  logic            n_i,
  input  logic            h_i,
  input  logic            c_i,
  output logic [DW-1:0]   res_o,
  output logic            res_we_o,
  output logic [WW-1:0]   wide_o,
  output logic            wide_we_o,
  output logic            z_o,
  output logic            n_o,
  output logic            h_o,
  output logic            c_o
);
  alu_op_e    op;
  alu_flags_t fin, fout;

  // Named internal events, visible to the bound checker.
  logic [DW-1:0] ar_res, lg_res, ar_b;
  logic          ar_half, ar_carry, ar_cin, ar_sub;
  logic [1:0]    lg_sel;
  logic [WW-1:0] wd_res;
  logic          wd_half, wd_carry, wd_ofs;

  assign op  = alu_op_e'(op_i);
  assign fin = '{z: z_i, n: n_i, h: h_i, c: c_i};

  assign ar_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
  assign ar_cin = ((op == OP_ADC) || (op == OP_SBC)) ? c_i : 1'b0;
  assign ar_b   = ((op == OP_INC) || (op == OP_DEC)) ? DW'(1) : opnd_i;
  assign lg_sel = (op == OP_AND) ? 2'd0 : (op == OP_OR) ? 2'd1 : 2'd2;
  assign wd_ofs = (op == OP_SPOFS);

  alu8_arith #(.W(DW)) u_arith (
    .a_i(acc_i), .b_i(ar_b), .cin_i(ar_cin), .sub_i(ar_sub),
    .res_o(ar_res), .half_o(ar_half), .carry_o(ar_carry)
  );

  alu8_logic #(.W(DW)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  alu8_wide #(.W(DW), .NW(WW)) u_wide (
    .base_i(pair_a_i), .pair_i(pair_b_i), .ofs_i(opnd_i), .ofs_mode_i(wd_ofs),
    .res_o(wd_res), .half_o(wd_half), .carry_o(wd_carry)
  );

  always_comb begin
    res_o     = acc_i;
    res_we_o  = 1'b0;
    wide_o    = pair_a_i;
    wide_we_o = 1'b0;
    fout      = fin;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        res_o    = ar_res;
        res_we_o = (op != OP_CMP);
        fout     = '{z: (ar_res == '0), n: ar_sub, h: ar_half, c: ar_carry};
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o    = lg_res;
        res_we_o = 1'b1;
        fout     = '{z: (lg_res == '0), n: 1'b0, h: (op == OP_AND), c: 1'b0};
      end
      OP_INC, OP_DEC: begin
        res_o    = ar_res;
        res_we_o = 1'b1;
        fout     = '{z: (ar_res == '0), n: ar_sub, h: ar_half, c: c_i};
      end
      OP_NOT: begin
        res_o    = ~acc_i;
        res_we_o = 1'b1;
        fout.n   = 1'b1;
        fout.h   = 1'b1;
      end
      OP_SETC, OP_FLIPC: begin
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = (op == OP_SETC) ? 1'b1 : ~c_i;
      end
      OP_PADD, OP_SPOFS: begin
        wide_o    = wd_res;
        wide_we_o = 1'b1;
        fout      = '{z: (wd_ofs ? 1'b0 : z_i), n: 1'b0, h: wd_half, c: wd_carry};
      end
      default: ;
    endcase
  end

  assign z_o = fout.z;
  assign n_o = fout.n;
  assign h_o = fout.h;
  assign c_o = fout.c;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DW = alu8_pkg::DATA_W
) (
  input logic [OP_W-1:0] op_i,
  input logic [DW-1:0]   acc_i,
  input logic            z_i,
  input logic            n_i,
  input logic            h_i,
  input logic            c_i,
  input logic [DW-1:0]   res_o,
  input logic            res_we_o,
  input logic            wide_we_o,
  input logic            z_o,
  input logic            n_o,
  input logic            h_o,
  input logic            c_o,
  input logic            ar_carry
);
  logic undef_op, wide_op;
  assign undef_op = (op_i > OP_SPOFS);
  assign wide_op  = (op_i == OP_PADD) || (op_i == OP_SPOFS);

  always_comb begin
    p_sub_n_set_r2:     assert (!(op_i == OP_SUB || op_i == OP_SBC) || (n_o && c_o == ar_carry));
    p_cmp_no_write_r3:  assert (op_i != OP_CMP || (!res_we_o && n_o && c_o == ar_carry));
    p_and_flags_r4:     assert (op_i != OP_AND || (h_o && !c_o && !n_o));
    p_incdec_keep_c_r5: assert (!(op_i == OP_INC || op_i == OP_DEC) || c_o == c_i);
    p_not_keep_r6:      assert (op_i != OP_NOT || (z_o == z_i && c_o == c_i && res_o == ~acc_i && n_o && h_o));
    p_carry_ops_r7:     assert (!(op_i == OP_SETC || op_i == OP_FLIPC) ||
                                (!n_o && !h_o && z_o == z_i && !res_we_o && c_o == ((op_i == OP_SETC) | ~c_i)));
    p_pair_keep_z_r8:   assert (op_i != OP_PADD || (z_o == z_i && !n_o));
    p_spofs_clr_r9:     assert (op_i != OP_SPOFS || (!z_o && !n_o));
    p_undef_hold_r10:   assert (!undef_op || (res_o == acc_i && !res_we_o && !wide_we_o &&
                                 z_o == z_i && n_o == n_i && h_o == h_i && c_o == c_i));
    p_we_exclusive_r11: assert (!(res_we_o && wide_we_o) && (!wide_op || !res_we_o));
  end
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
  .op_i(op_i), .acc_i(acc_i), .z_i(z_i), .n_i(n_i), .h_i(h_i), .c_i(c_i),
  .res_o(res_o), .res_we_o(res_we_o), .wide_we_o(wide_we_o),
  .z_o(z_o), .n_o(n_o), .h_o(h_o), .c_o(c_o), .ar_carry(ar_carry)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [4:0]  op;
  logic [7:0]  acc, opnd, res;
  logic [15:0] pa, pb, wres;
  logic        zi, ni, hi, ci, res_we, wide_we, zo, no, ho, co;

  alu8_core u_dut (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .pair_a_i(pa), .pair_b_i(pb),
    .z_i(zi), .n_i(ni), .h_i(hi), .c_i(ci),
    .res_o(res), .res_we_o(res_we), .wide_o(wres), .wide_we_o(wide_we),
    .z_o(zo), .n_o(no), .h_o(ho), .c_o(co)
  );

  typedef struct {
    int    r8;
    int    r16;
    bit    we8;
    bit    we16;
    bit [3:0] fl;    // {z,n,h,c}
    string tag;
    int    opc;
  } exp_t;

  exp_t exp_q[$];
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  function automatic string tag_of(int o);
    case (o)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4:       return "R3";
      5, 6, 7: return "R4";
      8, 9:    return "R5";
      10:      return "R6";
      11, 12:  return "R7";
      13:      return "R8";
      14:      return "R9";
      default: return "R10";
    endcase
  endfunction

  // Independent model written from the requirements with integer arithmetic.
  function automatic exp_t model(int o, int a, int b, int wa, int wb, bit [3:0] f);
    exp_t e;
    int s, off;
    bit z = f[3], n = f[2], h = f[1], c = f[0];
    int cin = (o == 1 || o == 3) ? int'(c) : 0;
    e.r8 = a; e.r16 = wa; e.we8 = 0; e.we16 = 0;
    case (o)
      0, 1: begin
        s = a + b + cin; e.r8 = s % 256; e.we8 = 1;
        z = (e.r8 == 0); n = 0; h = ((a % 16) + (b % 16) + cin) > 15; c = s > 255;
      end
      2, 3, 4: begin
        s = a - b - cin; e.r8 = (s + 256) % 256; e.we8 = (o != 4);
        z = (e.r8 == 0); n = 1; h = ((a % 16) - (b % 16) - cin) < 0; c = s < 0;
      end
      5, 6, 7: begin
        e.r8 = (o == 5) ? (a & b) : (o == 6) ? (a | b) : (a ^ b); e.we8 = 1;
        z = (e.r8 == 0); n = 0; h = (o == 5); c = 0;
      end
      8: begin e.r8 = (a + 1) % 256; e.we8 = 1; z = (e.r8 == 0); n = 0; h = (a % 16) == 15; end
      9: begin e.r8 = (a + 255) % 256; e.we8 = 1; z = (e.r8 == 0); n = 1; h = (a % 16) == 0; end
      10: begin e.r8 = 255 - a; e.we8 = 1; n = 1; h = 1; end
      11: begin n = 0; h = 0; c = 1; end
      12: begin n = 0; h = 0; c = !c; end
      13: begin
        s = wa + wb; e.r16 = s % 65536; e.we16 = 1;
        n = 0; h = ((wa % 4096) + (wb % 4096)) > 4095; c = s > 65535;
      end
      14: begin
        off = (b >= 128) ? b - 256 : b;
        e.r16 = (wa + off + 65536) % 65536; e.we16 = 1;
        z = 0; n = 0; h = ((wa % 16) + (b % 16)) > 15; c = ((wa % 256) + b) > 255;
      end
      default: ;
    endcase
    e.fl = {z, n, h, c};
    e.tag = tag_of(o);
    e.opc = o;
    return e;
  endfunction

  task automatic drive(int o, int a, int b, int wa, int wb, bit [3:0] f);
    @(negedge clk);
    op = 5'(o); acc = 8'(a); opnd = 8'(b); pa = 16'(wa); pb = 16'(wb);
    {zi, ni, hi, ci} = f;
    exp_q.push_back(model(o, a, b, wa, wb, f));
  endtask

  // Monitor: results are combinational, due in the cycle the inputs were driven.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (res !== 8'(e.r8) || res_we !== e.we8 || wide_we !== e.we16 ||
          {zo, no, ho, co} !== e.fl || (e.we16 && wres !== 16'(e.r16))) begin
        failures++;
        $display("FAIL %s op=%0d res=%h/%h we=%b%b/%b%b flags=%b/%b wide=%h/%h",
                 e.tag, e.opc, res, 8'(e.r8), res_we, wide_we, e.we8, e.we16,
                 {zo, no, ho, co}, e.fl, wres, 16'(e.r16));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int corners[6] = '{8'h00, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF};
    op = 5'h1F; acc = 8'h00; opnd = 8'h00; pa = 16'h0; pb = 16'h0;
    {zi, ni, hi, ci} = 4'b0000;
    // Idle state with an undefined code: R10 pass-through.
    drive(31, 8'h5A, 8'h00, 16'h1234, 16'h0, 4'b1010);
    // Corner sweep over every code, R1..R11.
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 2; k++)
            drive(o, corners[i], corners[j], {corners[j], corners[i]},
                  {corners[i], corners[j]}, {1'(i), 1'(j), 1'(i + j), 1'(k)});
    // Wide edges: R8 bit-11 and bit-15 carries, R9 negative offsets.
    drive(13, 0, 0, 16'h0FFF, 16'h0001, 4'b1000);
    drive(13, 0, 0, 16'hFFFF, 16'h0001, 4'b0000);
    drive(13, 0, 0, 16'h8000, 16'h7FFF, 4'b1111);
    drive(14, 0, 8'hFF, 16'h0000, 0, 4'b1111);
    drive(14, 0, 8'h80, 16'h00FF, 0, 4'b0000);
    drive(14, 0, 8'h01, 16'hFFFF, 0, 4'b1000);
    // Random operands on all codes.
    for (int r = 0; r < 3000; r++)
      drive(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), 4'($urandom));
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule